// File: doc/BRIEF.md
# Receive Fill-Suppressing Data Strobe Generator

This block sits behind the character decoder and word aligner of a serial-link receiver. It issues an active-low ready strobe, one per character period, that tells a downstream FIFO which decoded characters are worth storing. It drops the strobe for runs of pad characters (the idle character, special code 0x05) so that a FIFO is not filled with filler. It also drops the strobe while the link is still hunting for character alignment.

Every character passes through a one-slot holding register. The strobe decision for a pad character therefore waits until its successor is known. The delayed character is presented on registered outputs. The strobe goes low at the same clock edge and stays low for a fixed number of bit ticks.

Two state machines carry the behaviour. The framing tracker has the states `ST_HUNT` (no alignment) and `ST_LOCKED` (aligned), with these transitions:
- hunt-to-locked when `framed_in` is high.
- locked-to-hunt when `reframe_en` is high and `framed_in` is low.

The pulse shaper has the states `SH_IDLE` (strobe high) and `SH_LOW` (strobe low, counting ticks), with these transitions:
- idle-to-low on a strobe decision.
- low-to-low (restart) on a new decision.
- low-to-idle when the last low tick has passed.

Top module: `rx_fill_strobe`

## Requirements
- R1: `rdy_n` is active low. A strobe drives it low at the character edge, and it stays low for exactly LOW_TICKS (default 6) `bit_en` ticks out of a BIT_TICKS (default 10) tick character period.
- R2: On every `char_en` edge, `out_data`, `out_special` and `out_viol` take together the character that was accepted on the previous `char_en` edge, so there is one character slot of latency.
- R3: A pad character that is followed directly by another pad character gets no strobe. A pad character is `special`=1, `data`=8'h05, `viol`=0.
- R4: A pad character followed by any non-pad character gets a strobe. This includes a violation and other special codes, so the last pad of a run is strobed.
- R5: When the link is locked, or when `reframe_en` is low, non-pad characters are strobed.
- R6: A character with `special`=1 and `data`=8'h05 but `viol`=1 is not a pad character and is strobed like data.
- R7: In the hunt state with `reframe_en` high and `bypass` low, no strobe is issued. The tracker leaves the hunt state in the clock after `framed_in` is high.
- R8: A locked link returns to the hunt state in the clock after `reframe_en` is high while `framed_in` is low.
- R9: With `bypass` and `reframe_en` both high, every pad character is strobed, including those inside a run, and no non-pad character is strobed, in any framing state.
- R10: Reset forces `rdy_n` high, clears the holding and output registers to zero, and enters the hunt state.
- R11: The first character delivered after reset comes from the empty holding register. It is all zero and is not strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-time tick enable, sets the strobe width |
| char_en | input | 1 | Character clock enable, one clock per character |
| in_data | input | 8 | Decoded character bits |
| in_special | input | 1 | 1 = special character, 0 = data |
| in_viol | input | 1 | Code violation or illegal character |
| bypass | input | 1 | Bypass (undecoded) mode select |
| reframe_en | input | 1 | Alignment search enabled |
| framed_in | input | 1 | Character alignment acquired |
| out_data | output | 8 | Delayed character bits |
| out_special | output | 1 | Delayed special/data flag |
| out_viol | output | 1 | Delayed violation flag |
| rdy_n | output | 1 | Active-low ready strobe |

## Verification
The embedded properties watch every character edge. They check that outputs equal the previously held character, that a pad followed by a pad and any hunt-state character leave the strobe high, and that a pad followed by a non-pad pulls it low. They also check that bypass mode suppresses non-pad strobes and that the framing tracker moves on `framed_in` and `reframe_en`. Only the scenarios can show the complete accounting across a stream: pad runs of several lengths, a pad ahead of a violation, a violated 0x05 special, leaving hunt mode, and bypass runs. The scoreboard compares each delivered character and strobe with its reference queue and measures every low pulse width.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    localparam int CHAR_W = 8;
    localparam logic [CHAR_W-1:0] PAD_CODE = 8'h05;

    typedef struct packed {
        logic              special;
        logic              viol;
        logic [CHAR_W-1:0] data;
    } char_t;

    typedef enum logic {ST_HUNT, ST_LOCKED} frame_st_e;
    typedef enum logic {SH_IDLE, SH_LOW}    shape_st_e;

    function automatic logic is_pad(input char_t c);
        return c.special && !c.viol && (c.data == PAD_CODE);
    endfunction

endpackage

// File: rtl/frame_track.sv
module frame_track
    import rfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reframe_en,
    input  logic framed_in,
    output logic hunting
);

    frame_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:   if (framed_in)                st_d = ST_LOCKED;
            ST_LOCKED: if (reframe_en && !framed_in) st_d = ST_HUNT;
            default:   st_d = ST_HUNT;
        endcase
    end

    always_comb hunting = (st_q == ST_HUNT);

    AST_LOCK_ON_FRAMED: assert property (@(posedge clk) disable iff (!rst_n)
        framed_in |=> !hunting);                                  // R7
    AST_DROP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (reframe_en && !framed_in) |=> hunting);                  // R8

endmodule

// File: rtl/fill_judge.sv
module fill_judge
    import rfs_pkg::*;
(
    input  logic  char_en,
    input  logic  hold_vld,
    input  char_t hold_c,
    input  char_t next_c,
    input  logic  bypass,
    input  logic  reframe_en,
    input  logic  hunting,
    output logic  fire
);

    logic hold_pad, next_pad, keep;

    always_comb begin
        hold_pad = is_pad(hold_c);
        next_pad = is_pad(next_c);
        if (!hold_vld)                     keep = 1'b0;
        else if (bypass && reframe_en)     keep = hold_pad;
        else if (reframe_en && hunting)    keep = 1'b0;
        else if (hold_pad && next_pad)     keep = 1'b0;
        else                               keep = 1'b1;
        fire = char_en && keep;
    end

endmodule

// File: rtl/strobe_shaper.sv
module strobe_shaper
    import rfs_pkg::*;
#(
    parameter int LOW_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic fire,
    output logic rdy_n
);

    localparam int CW = (LOW_TICKS > 1) ? $clog2(LOW_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOW_TICKS - 1);

    shape_st_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rdy_q, rdy_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SH_IDLE;
            cnt_q <= '0;
            rdy_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rdy_q <= rdy_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        rdy_d = rdy_q;
        unique case (st_q)
            SH_IDLE: begin
                if (fire) begin
                    st_d  = SH_LOW;
                    cnt_d = LAST;
                    rdy_d = 1'b0;
                end
            end
            SH_LOW: begin
                if (fire) begin
                    cnt_d = LAST;
                    rdy_d = 1'b0;
                end else if (bit_en) begin
                    if (cnt_q == '0) begin
                        st_d  = SH_IDLE;
                        rdy_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                st_d  = SH_IDLE;
                rdy_d = 1'b1;
            end
        endcase
    end

    assign rdy_n = rdy_q;

    AST_FIRE_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !rdy_n);                                         // R1
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_n) |-> $past(bit_en));                          // R1

endmodule

// File: rtl/rx_fill_strobe.sv
module rx_fill_strobe
    import rfs_pkg::*;
#(
    parameter int BIT_TICKS = 10,
    parameter int LOW_TICKS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              char_en,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_special,
    input  logic              in_viol,
    input  logic              bypass,
    input  logic              reframe_en,
    input  logic              framed_in,
    output logic [CHAR_W-1:0] out_data,
    output logic              out_special,
    output logic              out_viol,
    output logic              rdy_n
);

    initial begin
        if (LOW_TICKS < 1 || LOW_TICKS >= BIT_TICKS)
            $error("LOW_TICKS must lie in 1..BIT_TICKS-1");
    end

    char_t next_c, hold_q, out_q;
    logic  hold_vld_q;
    logic  hunting, fire;

    always_comb next_c = '{special: in_special, viol: in_viol, data: in_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
            out_q      <= '0;
        end else if (char_en) begin
            hold_q     <= next_c;
            hold_vld_q <= 1'b1;
            out_q      <= hold_q;
        end
    end

    assign out_data    = out_q.data;
    assign out_special = out_q.special;
    assign out_viol    = out_q.viol;

    frame_track u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .reframe_en (reframe_en),
        .framed_in  (framed_in),
        .hunting    (hunting)
    );

    fill_judge u_judge (
        .char_en    (char_en),
        .hold_vld   (hold_vld_q),
        .hold_c     (hold_q),
        .next_c     (next_c),
        .bypass     (bypass),
        .reframe_en (reframe_en),
        .hunting    (hunting),
        .fire       (fire)
    );

    strobe_shaper #(.LOW_TICKS(LOW_TICKS)) u_shape (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .fire   (fire),
        .rdy_n  (rdy_n)
    );

    AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        char_en |=> ({out_special, out_viol, out_data} == $past(hold_q)));          // R2
    AST_FILL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !bypass && is_pad(hold_q) && is_pad(next_c)) |=> rdy_n);        // R3
    AST_PAD_TAIL_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !bypass && !hunting && hold_vld_q && is_pad(hold_q)
         && !is_pad(next_c)) |=> !rdy_n);                                           // R4
    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && hunting && reframe_en && !bypass) |=> rdy_n);                   // R7
    AST_BYPASS_NONPAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && bypass && reframe_en && !is_pad(hold_q)) |=> rdy_n);            // R9
    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (char_en && !hold_vld_q) |=> rdy_n);                                        // R11

endmodule

// File: tb/rx_fill_strobe_test.sv
module rx_fill_strobe_test;

    localparam int BT = 10;
    localparam int LT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b1;
    logic       char_en = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_special = 1'b0;
    logic       in_viol = 1'b0;
    logic       bypass = 1'b0;
    logic       reframe_en = 1'b1;
    logic       framed_in = 1'b0;
    logic [7:0] out_data;
    logic       out_special, out_viol, rdy_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rx_fill_strobe #(.BIT_TICKS(BT), .LOW_TICKS(LT)) uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .char_en(char_en),
        .in_data(in_data), .in_special(in_special), .in_viol(in_viol),
        .bypass(bypass), .reframe_en(reframe_en), .framed_in(framed_in),
        .out_data(out_data), .out_special(out_special), .out_viol(out_viol),
        .rdy_n(rdy_n)
    );

    // reference model state
    logic [9:0] prev_c = '0;
    logic       prev_vld = 1'b0;
    logic       m_hunt = 1'b1;
    logic [10:0] exp_q[$];
    string       tag_q[$];

    function automatic logic pad(input logic [9:0] c);
        return c[9] && !c[8] && c[7:0] == 8'h05;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic set_mode(input logic bp, input logic rf, input logic fr);
        @(negedge clk);
        bypass = bp; reframe_en = rf; framed_in = fr;
        if (fr) m_hunt = 1'b0;
        else if (rf) m_hunt = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic sp, input logic vi, input logic [7:0] d, input string tag);
        logic [9:0] cur;
        logic       st;
        cur = {sp, vi, d};
        if (!prev_vld)                 st = 1'b0;
        else if (bypass && reframe_en) st = pad(prev_c);
        else if (reframe_en && m_hunt) st = 1'b0;
        else if (pad(prev_c) && pad(cur)) st = 1'b0;
        else                           st = 1'b1;
        exp_q.push_back({st, prev_c});
        tag_q.push_back(tag);
        prev_c = cur; prev_vld = 1'b1;
        @(negedge clk);
        in_special = sp; in_viol = vi; in_data = d; char_en = 1'b1;
        @(negedge clk);
        char_en = 1'b0;
        repeat (BT - 1) @(negedge clk);
    endtask

    task automatic pads(input int n, input string tag);
        for (int i = 0; i < n; i++) send(1'b1, 1'b0, 8'h05, tag);
    endtask

    // monitor: compare each delivered character against the queue
    initial begin
        forever begin
            @(posedge clk);
            if (char_en) begin
                logic [10:0] e;
                string t;
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected delivery", 0, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({out_special, out_viol, out_data} == e[9:0], {t, "/R2"}, "char",
                          {22'd0, out_special, out_viol, out_data}, {22'd0, e[9:0]});
                    check(rdy_n == !e[10], t, "strobe rdy_n", {31'd0, rdy_n}, {31'd0, !e[10]});
                end
            end
        end
    end

    // pulse width measurement, R1
    int low_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!rdy_n) low_run++;
            else if (low_run != 0) begin
                check(low_run == LT, "R1", "low width", low_run, LT);
                low_run = 0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "WATCHDOG", "timeout", 0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(rdy_n == 1'b1, "R10", "rdy_n in reset", {31'd0, rdy_n}, 1);
        check({out_special, out_viol, out_data} == 10'd0, "R10", "outputs in reset",
              {22'd0, out_special, out_viol, out_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(rdy_n == 1'b1, "R10", "rdy_n after reset", {31'd0, rdy_n}, 1);

        // hunting with reframe: no strobes; first delivery empty
        send(1'b0, 1'b0, 8'h11, "R11");
        send(1'b0, 1'b0, 8'h22, "R7");
        send(1'b1, 1'b0, 8'h05, "R7");
        set_mode(1'b0, 1'b1, 1'b1);
        // locked: data strobes, pad runs
        send(1'b0, 1'b0, 8'h33, "R5");
        send(1'b0, 1'b0, 8'h44, "R5");
        pads(4, "R3");
        send(1'b0, 1'b0, 8'h55, "R4");
        send(1'b1, 1'b0, 8'h3C, "R5");
        pads(1, "R4");
        send(1'b0, 1'b1, 8'hFF, "R4");
        pads(2, "R3");
        send(1'b1, 1'b1, 8'h05, "R6");
        pads(1, "R6");
        send(1'b1, 1'b0, 8'h3C, "R4");
        pads(7, "R3");
        send(1'b0, 1'b0, 8'h66, "R4");
        // lose lock
        set_mode(1'b0, 1'b1, 1'b0);
        send(1'b0, 1'b0, 8'h77, "R8");
        send(1'b0, 1'b0, 8'h88, "R8");
        pads(2, "R8");
        // reframe disabled while hunting: normal rules apply
        set_mode(1'b0, 1'b0, 1'b0);
        send(1'b0, 1'b0, 8'h99, "R5");
        pads(3, "R3");
        send(1'b0, 1'b0, 8'hAA, "R4");
        // bypass with reframe: each pad strobed, nothing else
        set_mode(1'b1, 1'b1, 1'b0);
        pads(3, "R9");
        send(1'b0, 1'b0, 8'hBB, "R9");
        send(1'b0, 1'b1, 8'hCC, "R9");
        pads(2, "R9");
        // bypass without reframe, locked: fill rules
        set_mode(1'b1, 1'b0, 1'b1);
        pads(3, "R3");
        send(1'b0, 1'b0, 8'hDD, "R4");
        send(1'b0, 1'b0, 8'hEE, "R5");
        repeat (BT + 4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "queue drained", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule